// File: doc/BRIEF.md
# Protected Paged Memory Command Engine

This block carries out the memory-level commands of a single-wire serial memory slave. It works on whole bytes only. The byte-level front end passes each byte received from the master in with `rx_valid`/`rx_byte`. It asks for the next byte to send back with a one-cycle `tx_req`. It pulses `bus_rst` whenever a bus reset is seen on the wire. The block holds a 128-byte array as registers, organised as 8 pages of 16 bytes. Pages 0 to 6 are user data. Page 7 holds the per-page write-mode nibbles and two manufacturer/user bytes. It also holds a factory word and the 64-bit device identifier.

Two commands exist. The sequential read takes a start address and streams bytes out. The segment write stores 2-byte segments. The master sends two bytes, receives them back as an echo, and then sends a release byte. The block waits a programming interval, commits the segment and returns a status byte. Each user page has a 4-bit write-mode code: open, AND-only or locked. Any nonzero code can be set once and never changed. A lock nibble freezes all of the mode codes. A factory word decides whether the manufacturer/user bytes may be written.

Top module: `pgmem_engine`

## Requirements
- R1: After `rst_n`, user bytes 00h–6Fh read FFh and mode bytes 70h–73h read 00h. Bytes 74h–75h read FFh. 76h holds `FACTORY_WORD[7:0]` and 77h holds `FACTORY_WORD[15:8]`. Byte 78h+i holds `DEVICE_ID[8i+7:8i]`. `tx_byte` reads FFh.
- R2: Read is command F0h, then a low-address byte (bit 7 must be 0, bits 6:0 give the start), then a high-address byte of 00h. Each `tx_req` then returns the byte at the address and advances it by one.
- R3: Once the read address passes 7Fh, every requested byte is FFh.
- R4: An unknown command byte, a read low byte with bit 7 set, or a nonzero read high byte makes every later requested byte FFh until `bus_rst`.
- R5: Write is command 55h, then a parameter byte (bit 7 and bit 0 must be 0, bits 6:4 page, bits 3:1 start segment), then b0 and b1. The next two requests return b0 and then b1. The master then sends release byte FFh. A request made during the following `PROG_CYCLES` cycles returns FFh. After those cycles the request returns AAh on success or 33h when the target is protected.
- R6: After an AAh status for segment 0–6, the next b0/b1 go to the following segment of the same page. After segment 7, or after a 33h status, requested bytes are FFh until `bus_rst`.
- R7: The mode nibble for page p is nibble p of bytes 70h–73h (low nibble of 70h is page 0, high nibble of 73h is the lock). Code 0h is open, Ah is AND-only, and any other code is locked. A write to a locked page returns 33h and leaves memory unchanged.
- R8: In AND-only mode the stored segment becomes the old data ANDed with the new data.
- R9: When 70h–73h are written, a nibble that already holds a nonzero value keeps it. A nonzero lock nibble makes writes to 70h–73h return 33h.
- R10: On page 7, start segments 3–7 are an invalid parameter (R11). Segment 2 (74h–75h) is writable only when the factory word is C3A9h. Segments 3–7 always return 33h.
- R11: An invalid write parameter, or any release byte other than FFh, commits nothing and makes later requested bytes FFh until `bus_rst`.
- R12: `bus_rst` at any point returns the block to waiting for a command. A segment whose programming interval has not ended is not committed.
- R13: `tx_byte` carries the answer to a `tx_req` from the clock edge that samples the request, one cycle later, and holds it until the next request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low; reloads the array |
| bus_rst | input | 1 | One-cycle strobe: a bus reset was seen |
| rx_valid | input | 1 | A byte from the master is on `rx_byte` this cycle |
| rx_byte | input | 8 | Byte received from the master |
| tx_req | input | 1 | The front end asks for the next byte to send |
| tx_byte | output | 8 | Byte to send, valid one cycle after `tx_req` |

## Verification
A bus reset and the end of the programming interval can land on the same cycle. If so, the abort must win and the segment must not be committed. The bench drives `bus_rst` in the middle of the programming wait. It then reads the whole array back against its own model to confirm the page kept its old contents. The mode-nibble merge and the commit also meet in one cycle when the mode bytes are rewritten. The bench writes zeros over nonzero nibbles and new codes over zero nibbles in the same segment. It then judges the result by readback and by the modes that later writes obey.

// File: rtl/pgmem_pkg.sv
package pgmem_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_RD_LO,
        S_RD_HI,
        S_RD_DATA,
        S_WR_PAR,
        S_WR_B0,
        S_WR_B1,
        S_WR_ECHO,
        S_WR_REL,
        S_WR_PROG,
        S_WR_STAT,
        S_DEAD
    } eng_state_e;

    typedef enum logic [1:0] {
        WM_OPEN,
        WM_AND,
        WM_LOCK
    } wmode_e;

    localparam logic [7:0]  CMD_READ     = 8'hF0;
    localparam logic [7:0]  CMD_WRITE    = 8'h55;
    localparam logic [7:0]  RELEASE_BYTE = 8'hFF;
    localparam logic [7:0]  STAT_OK      = 8'hAA;
    localparam logic [7:0]  STAT_PROT    = 8'h33;
    localparam logic [3:0]  CODE_AND     = 4'hA;
    localparam logic [15:0] FW_USER      = 16'hC3A9;

endpackage

// File: rtl/pgmem_array.sv
module pgmem_array #(
    parameter int                  SEGS = 64,
    parameter logic [SEGS*16-1:0]  INIT = '0,
    localparam int                 SW   = $clog2(SEGS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [SW-1:0]        wr_seg,
    input  logic [15:0]          wr_data,
    output logic [SEGS*16-1:0]   mem_q
);

    for (genvar g = 0; g < SEGS; g++) begin : g_seg
        logic [15:0] seg_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                seg_q <= INIT[g*16 +: 16];
            end else if (wr_en && wr_seg == SW'(g)) begin
                seg_q <= wr_data;
            end
        end
        assign mem_q[g*16 +: 16] = seg_q;
    end

endmodule

// File: rtl/pgmem_modesel.sv
module pgmem_modesel
    import pgmem_pkg::*;
(
    input  logic [31:0] prot,
    input  logic [15:0] fw,
    input  logic [2:0]  page,
    input  logic [2:0]  seg,
    output wmode_e      mode
);

    logic [3:0] nib;

    always_comb begin
        nib  = prot[{page, 2'b00} +: 4];
        mode = WM_LOCK;
        if (page != 3'd7) begin
            if (nib == 4'h0)          mode = WM_OPEN;
            else if (nib == CODE_AND) mode = WM_AND;
        end else if (seg < 3'd2) begin
            if (prot[31:28] == 4'h0)  mode = WM_OPEN;
        end else if (seg == 3'd2) begin
            if (fw == FW_USER)        mode = WM_OPEN;
        end
    end

endmodule

// File: rtl/pgmem_engine.sv
module pgmem_engine
    import pgmem_pkg::*;
#(
    parameter int          PROG_CYCLES  = 24,
    parameter logic [15:0] FACTORY_WORD = 16'hC3A9,
    parameter logic [63:0] DEVICE_ID    = 64'h9CA1B2C3D4E5F62B
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_rst,
    input  logic       rx_valid,
    input  logic [7:0] rx_byte,
    input  logic       tx_req,
    output logic [7:0] tx_byte
);

    localparam int CW       = $clog2(PROG_CYCLES + 1);
    localparam int BYTES    = 128;
    localparam int SEGS     = BYTES / 2;
    localparam int NIB_BASE = 8 * 8'h70;
    localparam logic [BYTES*8-1:0] INIT =
        {DEVICE_ID, FACTORY_WORD, 16'hFFFF, 32'h0, {112{8'hFF}}};

    typedef struct packed {
        eng_state_e    st;
        logic [7:0]    addr;
        logic [5:0]    sidx;
        logic [7:0]    b0;
        logic [7:0]    b1;
        logic          echo_hi;
        logic [CW-1:0] cnt;
        logic [7:0]    status;
        logic [7:0]    tx;
    } eng_t;

    eng_t          r_q, r_d;
    logic [BYTES*8-1:0] mem_q;
    wmode_e        mode;
    logic          wr_en;
    logic [15:0]   wr_data;
    logic [15:0]   old_seg, new_seg, merged;
    logic [7:0]    rd_byte;

    pgmem_array #(.SEGS(SEGS), .INIT(INIT)) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_seg  (r_q.sidx),
        .wr_data (wr_data),
        .mem_q   (mem_q)
    );

    pgmem_modesel u_modesel (
        .prot (mem_q[NIB_BASE +: 32]),
        .fw   (mem_q[8*8'h76 +: 16]),
        .page (r_q.sidx[5:3]),
        .seg  (r_q.sidx[2:0]),
        .mode (mode)
    );

    assign old_seg = mem_q[{r_q.sidx, 4'b0000} +: 16];
    assign new_seg = {r_q.b1, r_q.b0};
    assign rd_byte = mem_q[{r_q.addr[6:0], 3'b000} +: 8];

    always_comb begin
        for (int k = 0; k < 4; k++) begin
            merged[4*k +: 4] = (old_seg[4*k +: 4] != 4'h0) ? old_seg[4*k +: 4]
                                                           : new_seg[4*k +: 4];
        end
        if (mode == WM_AND)
            wr_data = old_seg & new_seg;
        else if (r_q.sidx[5:1] == 5'b11100)
            wr_data = merged;
        else
            wr_data = new_seg;
    end

    always_comb begin
        r_d   = r_q;
        wr_en = 1'b0;
        if (tx_req) r_d.tx = 8'hFF;
        if (bus_rst) begin
            r_d.st = S_IDLE;
        end else begin
            unique case (r_q.st)
                S_IDLE: if (rx_valid) begin
                    if (rx_byte == CMD_READ)       r_d.st = S_RD_LO;
                    else if (rx_byte == CMD_WRITE) r_d.st = S_WR_PAR;
                    else                           r_d.st = S_DEAD;
                end
                S_RD_LO: if (rx_valid) begin
                    r_d.addr = {1'b0, rx_byte[6:0]};
                    r_d.st   = rx_byte[7] ? S_DEAD : S_RD_HI;
                end
                S_RD_HI: if (rx_valid) begin
                    r_d.st = (rx_byte == 8'h00) ? S_RD_DATA : S_DEAD;
                end
                S_RD_DATA: if (tx_req) begin
                    if (!r_q.addr[7]) begin
                        r_d.tx   = rd_byte;
                        r_d.addr = r_q.addr + 8'd1;
                    end
                end
                S_WR_PAR: if (rx_valid) begin
                    if (rx_byte[7] || rx_byte[0] ||
                        (rx_byte[6:4] == 3'd7 && rx_byte[3:1] > 3'd2)) begin
                        r_d.st = S_DEAD;
                    end else begin
                        r_d.sidx = rx_byte[6:1];
                        r_d.st   = S_WR_B0;
                    end
                end
                S_WR_B0: if (rx_valid) begin
                    r_d.b0 = rx_byte;
                    r_d.st = S_WR_B1;
                end
                S_WR_B1: if (rx_valid) begin
                    r_d.b1      = rx_byte;
                    r_d.echo_hi = 1'b0;
                    r_d.st      = S_WR_ECHO;
                end
                S_WR_ECHO: if (tx_req) begin
                    r_d.tx      = r_q.echo_hi ? r_q.b1 : r_q.b0;
                    r_d.echo_hi = 1'b1;
                    if (r_q.echo_hi) r_d.st = S_WR_REL;
                end
                S_WR_REL: if (rx_valid) begin
                    r_d.cnt = CW'(PROG_CYCLES - 1);
                    r_d.st  = (rx_byte == RELEASE_BYTE) ? S_WR_PROG : S_DEAD;
                end
                S_WR_PROG: begin
                    if (r_q.cnt == '0) begin
                        wr_en      = (mode != WM_LOCK);
                        r_d.status = (mode != WM_LOCK) ? STAT_OK : STAT_PROT;
                        r_d.st     = S_WR_STAT;
                    end else begin
                        r_d.cnt = r_q.cnt - 1'b1;
                    end
                end
                S_WR_STAT: if (tx_req) begin
                    r_d.tx = r_q.status;
                    if (r_q.status == STAT_OK && r_q.sidx[2:0] != 3'd7) begin
                        r_d.sidx = r_q.sidx + 6'd1;
                        r_d.st   = S_WR_B0;
                    end else begin
                        r_d.st = S_DEAD;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q        <= '0;
            r_q.st     <= S_IDLE;
            r_q.tx     <= 8'hFF;
        end else begin
            r_q <= r_d;
        end
    end

    assign tx_byte = r_q.tx;

    a_r12_bus_reset_idle: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rst |=> (r_q.st == S_IDLE));

    a_r12_commit_only_at_prog_end: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rst || r_q.st != S_WR_PROG || r_q.cnt != '0) |=> $stable(mem_q));

    a_r7_locked_unchanged: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == S_WR_PROG && r_q.cnt == '0 && mode == WM_LOCK) |=> $stable(mem_q));

    a_r3_past_end_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == S_RD_DATA && tx_req && !bus_rst && r_q.addr[7]) |=> (tx_byte == 8'hFF));

    a_r5_status_code: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == S_WR_STAT && tx_req && !bus_rst)
        |=> (tx_byte == STAT_OK || tx_byte == STAT_PROT));

    for (genvar k = 0; k < 8; k++) begin : g_nib_chk
        a_r9_nibble_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            (mem_q[NIB_BASE + 4*k +: 4] != 4'h0) |=> $stable(mem_q[NIB_BASE + 4*k +: 4]));
    end

endmodule

// File: tb/test_pgmem_engine.sv
module test_pgmem_engine;

    localparam int          PROG = 24;
    localparam logic [63:0] DID  = 64'h9CA1B2C3D4E5F62B;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_rst = 1'b0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_byte = 8'h00;
    logic       tx_req = 1'b0;
    logic [7:0] tx_byte, tx_byte_fw;

    int n_chk = 0;
    int n_fail = 0;
    logic [7:0] exp_mem [128];
    logic [7:0] v;

    always #10 clk = ~clk;

    pgmem_engine #(.PROG_CYCLES(PROG), .FACTORY_WORD(16'hC3A9), .DEVICE_ID(DID)) i_pgmem_engine (
        .clk(clk), .rst_n(rst_n), .bus_rst(bus_rst), .rx_valid(rx_valid),
        .rx_byte(rx_byte), .tx_req(tx_req), .tx_byte(tx_byte));

    pgmem_engine #(.PROG_CYCLES(PROG), .FACTORY_WORD(16'h3C56), .DEVICE_ID(DID)) i_pgmem_engine_fw (
        .clk(clk), .rst_n(rst_n), .bus_rst(bus_rst), .rx_valid(rx_valid),
        .rx_byte(rx_byte), .tx_req(tx_req), .tx_byte(tx_byte_fw));

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] b);
        @(negedge clk); rx_valid = 1'b1; rx_byte = b;
        @(negedge clk); rx_valid = 1'b0;
    endtask

    task automatic recv(output logic [7:0] b);
        @(negedge clk); tx_req = 1'b1;
        @(negedge clk); tx_req = 1'b0;
        b = tx_byte;
    endtask

    task automatic breset();
        @(negedge clk); bus_rst = 1'b1;
        @(negedge clk); bus_rst = 1'b0;
    endtask

    task automatic rd_from(input string tag, input int start, input int count);
        breset();
        send(8'hF0); send(8'(start)); send(8'h00);
        for (int a = start; a < start + count; a++) begin
            recv(v);
            chk(tag, v, (a < 128) ? exp_mem[a] : 8'hFF);
        end
    endtask

    task automatic seg_flow(input string tag, input logic [7:0] b0, input logic [7:0] b1,
                            input logic [7:0] st);
        send(b0); send(b1);
        recv(v); chk({tag, " echo b0 R5"}, v, b0);
        recv(v); chk({tag, " echo b1 R5"}, v, b1);
        send(8'hFF);
        recv(v); chk({tag, " no early status R5"}, v, 8'hFF);
        repeat (PROG + 2) @(negedge clk);
        recv(v); chk({tag, " status"}, v, st);
    endtask

    initial begin
        for (int a = 0; a < 112; a++) exp_mem[a] = 8'hFF;
        for (int a = 112; a < 116; a++) exp_mem[a] = 8'h00;
        exp_mem[116] = 8'hFF; exp_mem[117] = 8'hFF;
        exp_mem[118] = 8'hA9; exp_mem[119] = 8'hC3;
        for (int i = 0; i < 8; i++) exp_mem[120 + i] = DID[8*i +: 8];

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 tx idle after reset", tx_byte, 8'hFF);
        rd_from("R1 R2 R3 reset image", 0, 130);
        rd_from("R2 R3 read near end", 8'h7D, 6);

        // R13: answer appears one edge after the request
        breset();
        send(8'hF0); send(8'h78); send(8'h00);
        @(negedge clk); tx_req = 1'b1;
        #1 chk("R13 not before edge", tx_byte, 8'hFF);
        @(negedge clk); tx_req = 1'b0;
        chk("R13 after one edge", tx_byte, exp_mem[8'h78]);
        @(negedge clk);
        chk("R13 holds", tx_byte, exp_mem[8'h78]);

        // R6: a whole page in one command, then ones
        breset();
        send(8'h55); send(8'h00);
        for (int s = 0; s < 8; s++) begin
            seg_flow("R6 page0 seg", 8'(16 * s + 1), 8'hF0 ^ 8'(s), 8'hAA);
            exp_mem[2*s] = 8'(16 * s + 1);
            exp_mem[2*s + 1] = 8'hF0 ^ 8'(s);
        end
        send(8'h12); send(8'h34);
        recv(v); chk("R6 ones after seg 7", v, 8'hFF);
        rd_from("R6 page0 readback", 0, 130);

        // R12: bus reset inside the programming wait
        breset();
        send(8'h55); send(8'h1A);
        send(8'h12); send(8'h34);
        recv(v); chk("R12 echo", v, 8'h12);
        recv(v);
        send(8'hFF);
        repeat (PROG / 2) @(negedge clk);
        breset();
        repeat (PROG + 4) @(negedge clk);
        rd_from("R12 aborted write not committed", 0, 130);

        // R7 R8: page 0 AND-only, page 1 locked
        breset();
        send(8'h55); send(8'h70);
        seg_flow("R7 set modes", 8'h5A, 8'h00, 8'hAA);
        exp_mem[8'h70] = 8'h5A;
        breset();
        send(8'h55); send(8'h00);
        seg_flow("R8 and-only write", 8'h3C, 8'hFF, 8'hAA);
        exp_mem[0] = exp_mem[0] & 8'h3C;
        exp_mem[1] = exp_mem[1] & 8'hFF;
        breset();
        send(8'h55); send(8'h10);
        seg_flow("R7 locked page", 8'h00, 8'h00, 8'h33);
        send(8'h00); send(8'h00);
        recv(v); chk("R7 R6 ones after 33h", v, 8'hFF);
        rd_from("R7 R8 readback", 0, 130);

        // R9: nonzero nibbles stick, zero nibbles take new codes
        breset();
        send(8'h55); send(8'h70);
        seg_flow("R9 rewrite modes", 8'h00, 8'hC0, 8'hAA);
        exp_mem[8'h71] = 8'hC0;
        breset();
        send(8'h55); send(8'h30);
        seg_flow("R9 page3 locked by new code", 8'h00, 8'h00, 8'h33);
        breset();
        send(8'h55); send(8'h72);
        seg_flow("R9 set lock nibble", 8'h00, 8'h30, 8'hAA);
        exp_mem[8'h73] = 8'h30;
        breset();
        send(8'h55); send(8'h70);
        seg_flow("R9 lock blocks mode bytes", 8'h00, 8'h00, 8'h33);
        rd_from("R9 readback", 8'h68, 24);

        // R10: manufacturer bytes depend on the factory word
        breset();
        send(8'h55); send(8'h74);
        send(8'h77); send(8'h88);
        recv(v); chk("R10 echo b0", v, 8'h77);
        recv(v);
        send(8'hFF);
        repeat (PROG + 2) @(negedge clk);
        recv(v);
        chk("R10 user word writable", v, 8'hAA);
        chk("R10 manufacturer word locked", tx_byte_fw, 8'h33);
        exp_mem[8'h74] = 8'h77; exp_mem[8'h75] = 8'h88;
        seg_flow("R10 factory word segment", 8'h00, 8'h00, 8'h33);
        breset();
        send(8'h55); send(8'h76);
        send(8'h11); send(8'h22);
        recv(v); chk("R10 page7 seg3 parameter invalid", v, 8'hFF);
        rd_from("R10 readback", 8'h70, 16);

        // R11: invalid parameter and missing release
        breset();
        send(8'h55); send(8'h01);
        send(8'h11); send(8'h22);
        recv(v); chk("R11 parameter bit0 set", v, 8'hFF);
        breset();
        send(8'h55); send(8'h80);
        send(8'h11); send(8'h22);
        recv(v); chk("R11 parameter bit7 set", v, 8'hFF);
        breset();
        send(8'h55); send(8'h20);
        send(8'h11); send(8'h22);
        recv(v); chk("R11 echo", v, 8'h11);
        recv(v);
        send(8'h00);
        repeat (PROG + 2) @(negedge clk);
        recv(v); chk("R11 no status without release", v, 8'hFF);
        rd_from("R11 readback", 0, 130);

        // R4: invalid command and read parameters
        breset();
        send(8'h99); send(8'hF0); send(8'h00); send(8'h00);
        recv(v); chk("R4 unknown command", v, 8'hFF);
        breset();
        send(8'hF0); send(8'h80); send(8'h00);
        recv(v); chk("R4 read low byte bit7", v, 8'hFF);
        breset();
        send(8'hF0); send(8'h02); send(8'h01);
        recv(v); chk("R4 read high byte nonzero", v, 8'hFF);
        rd_from("R4 recovery after bus reset", 2, 4);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got hang expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule